// File: doc/BRIEF.md
# Cascadable Presettable Binary Up-Counter

This block is a small synchronous binary up-counter, four bits wide by default. It can be preset from a parallel data input, and it has two count enables that are ANDed together. It drives a terminal-count output so that several stages can be chained into a wider counter. Every change of the count occurs on the rising clock edge. The one exception is reset when the block is built in its asynchronous variant: that reset takes effect at once, without a clock.

The stage applies its operations in a fixed order of priority: reset first, then parallel preset, then increment, then hold. Reset and preset are active-low. Both enables are active-high. The terminal-count output is gated only by the trickle enable, so the parallel enable has no effect on it. To build a wider counter, drive each stage's trickle enable from the terminal count of the stage below it. All stages share the parallel enable, the clock and the controls. The build-time parameter `ASYNC_RESET` selects the reset style.

Top module: `cascade_counter`

## Requirements
- R1: The count follows a modulo-2^WIDTH binary sequence. With the default WIDTH of 4, an increment from 15 (all ones) gives 0.
- R2: When rstN and loadN are both high, a rising clock edge adds one to the count only if enParallel and enTrickle are both high.
- R3: When rstN and loadN are high and either enable is low, the count keeps its value across clock edges.
- R4: When loadN is low and rstN is high, the next rising edge captures dataIn, whatever the enables are.
- R5: A low rstN takes priority over loadN and both enables, and it brings the count to 0. This holds in both reset variants.
- R6: With ASYNC_RESET=1, a falling rstN sets the count to 0 at once, without waiting for a clock edge.
- R7: With ASYNC_RESET=0, a low rstN changes nothing until the next rising clock edge, which sets the count to 0.
- R8: termCount is high exactly when the count is all ones and enTrickle is high. enParallel does not affect it, and a preset value of all ones raises it without any clock edge after the load.
- R9: Two stages chained by feeding the lower stage's termCount to the upper stage's enTrickle form an 8-bit counter. This counter wraps from 255 to 0, and its upper termCount is high at 255 when the chain's trickle enable is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low reset; asynchronous or synchronous according to ASYNC_RESET |
| loadN | input | 1 | Active-low parallel preset |
| enParallel | input | 1 | Count enable that does not affect termCount |
| enTrickle | input | 1 | Count enable that also gates termCount |
| dataIn | input | WIDTH | Parallel preset value |
| countOut | output | WIDTH | Registered count |
| termCount | output | 1 | High when the count is all ones and enTrickle is high |

## Verification
Two pairs of operations can be requested in the same cycle, and the priority order decides both. Preset against increment is provoked by holding loadN low while both enables are high. Reset against preset is provoked by holding rstN low while loadN is also low. In each case an 8-bit arithmetic model in the bench computes the count that should result, and the count of each chained pair must equal it after the edge. The reset timing is judged by dropping rstN in the middle of a clock cycle. The asynchronous chain must already read zero before the next edge, while the synchronous chain must still hold its old value until that edge.

// File: rtl/counter_pkg.sv
package counter_pkg;
  // Strobes from control to datapath; at most one is high in any cycle.
  typedef struct packed {
    logic clear;  // synchronous clear (used by the synchronous variant)
    logic load;   // capture the parallel data
    logic step;   // add one
  } ctrlStrobes_t;
endpackage

// File: rtl/counter_ctrl.sv
module counter_ctrl
  import counter_pkg::*;
#(
  parameter bit ASYNC_RESET = 1'b1
) (
  input  logic         rstN,
  input  logic         loadN,
  input  logic         enParallel,
  input  logic         enTrickle,
  output ctrlStrobes_t strobes
);
  logic resetActive;
  logic loadActive;
  logic stepActive;

  // Priority order: reset, then preset, then increment, then hold.
  always_comb begin
    resetActive = !rstN;
    loadActive  = rstN && !loadN;
    stepActive  = rstN && loadN && enParallel && enTrickle;
  end

  generate
    if (ASYNC_RESET) begin : g_asyncCtrl
      // The flops clear themselves asynchronously, so no clear strobe is sent.
      assign strobes.clear = 1'b0;
    end else begin : g_syncCtrl
      assign strobes.clear = resetActive;
    end
  endgenerate

  assign strobes.load = loadActive;
  assign strobes.step = stepActive;
endmodule

// File: rtl/counter_datapath.sv
module counter_datapath
  import counter_pkg::*;
#(
  parameter int unsigned WIDTH       = 4,
  parameter bit          ASYNC_RESET = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [WIDTH-1:0] dataIn,
  input  logic             enTrickle,
  output logic [WIDTH-1:0] countOut,
  output logic             termCount
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE      = WIDTH'(1);

  logic [WIDTH-1:0] countReg;
  logic [WIDTH-1:0] nextCount;

  always_comb begin
    nextCount = countReg;
    if (strobes.clear)     nextCount = '0;
    else if (strobes.load) nextCount = dataIn;
    else if (strobes.step) nextCount = countReg + ONE;
  end

  generate
    if (ASYNC_RESET) begin : g_asyncFlops
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) countReg <= '0;
        else       countReg <= nextCount;
      end
    end else begin : g_syncFlops
      always_ff @(posedge clk) begin
        countReg <= nextCount;
      end
    end
  endgenerate

  assign countOut  = countReg;
  assign termCount = (countReg == ALL_ONES) && enTrickle;
endmodule

// File: rtl/cascade_counter.sv
module cascade_counter
  import counter_pkg::*;
#(
  parameter int unsigned WIDTH       = 4,
  parameter bit          ASYNC_RESET = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadN,
  input  logic             enParallel,
  input  logic             enTrickle,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] countOut,
  output logic             termCount
);
  ctrlStrobes_t strobes;

  counter_ctrl #(.ASYNC_RESET(ASYNC_RESET)) uCtrl (
    .rstN       (rstN),
    .loadN      (loadN),
    .enParallel (enParallel),
    .enTrickle  (enTrickle),
    .strobes    (strobes)
  );

  counter_datapath #(.WIDTH(WIDTH), .ASYNC_RESET(ASYNC_RESET)) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .dataIn    (dataIn),
    .enTrickle (enTrickle),
    .countOut  (countOut),
    .termCount (termCount)
  );
endmodule

// File: rtl/counter_checker.sv
module counter_checker #(
  parameter int unsigned WIDTH       = 4,
  parameter bit          ASYNC_RESET = 1'b1
) (
  input logic             clk,
  input logic             rstN,
  input logic             loadN,
  input logic             enParallel,
  input logic             enTrickle,
  input logic [WIDTH-1:0] dataIn,
  input logic [WIDTH-1:0] countOut,
  input logic             termCount
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  // Becomes 1 after the first clock edge seen with reset low.
  logic armed;
  always_ff @(posedge clk) begin
    if (!rstN) armed <= 1'b1;
  end

  assert_reset_clears_R5: assert property (@(posedge clk) disable iff (armed !== 1'b1)
    !rstN |=> countOut == '0);

  assert_load_wins_R4: assert property (@(posedge clk) disable iff (!rstN || armed !== 1'b1)
    !loadN |=> countOut == $past(dataIn));

  assert_step_R2: assert property (@(posedge clk) disable iff (!rstN || armed !== 1'b1)
    (loadN && enParallel && enTrickle) |=> countOut == $past(countOut) + ONE);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rstN || armed !== 1'b1)
    (loadN && !(enParallel && enTrickle)) |=> $stable(countOut));

  assert_tc_gated_R8: assert property (@(posedge clk) disable iff (!rstN || armed !== 1'b1)
    termCount |-> (enTrickle && (&countOut)));

  generate
    if (ASYNC_RESET) begin : g_asyncChk
      assert_async_zero_R6: assert property (@(posedge clk) disable iff (armed !== 1'b1)
        !rstN |-> countOut == '0);
    end
  endgenerate
endmodule

bind cascade_counter counter_checker #(.WIDTH(WIDTH), .ASYNC_RESET(ASYNC_RESET)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .loadN      (loadN),
  .enParallel (enParallel),
  .enTrickle  (enTrickle),
  .dataIn     (dataIn),
  .countOut   (countOut),
  .termCount  (termCount)
);

// File: tb/sim_cascade_counter.sv
`timescale 1ns/1ps
module sim_cascade_counter;
  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic       rstN = 1'b0, loadN = 1'b1, enP = 1'b0, enT = 1'b0;
  logic [7:0] dataIn = 8'h00;

  logic [3:0] loA, hiA, loS, hiS;
  logic       tcLoA, tcHiA, tcLoS, tcHiS;

  // Asynchronous-reset chain: u0 low nibble, u1 high nibble.
  cascade_counter #(.WIDTH(4), .ASYNC_RESET(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .loadN(loadN), .enParallel(enP), .enTrickle(enT),
    .dataIn(dataIn[3:0]), .countOut(loA), .termCount(tcLoA));
  cascade_counter #(.WIDTH(4), .ASYNC_RESET(1'b1)) u1 (
    .clk(clk), .rstN(rstN), .loadN(loadN), .enParallel(enP), .enTrickle(tcLoA),
    .dataIn(dataIn[7:4]), .countOut(hiA), .termCount(tcHiA));
  // Synchronous-reset chain: u2 low nibble, u3 high nibble.
  cascade_counter #(.WIDTH(4), .ASYNC_RESET(1'b0)) u2 (
    .clk(clk), .rstN(rstN), .loadN(loadN), .enParallel(enP), .enTrickle(enT),
    .dataIn(dataIn[3:0]), .countOut(loS), .termCount(tcLoS));
  cascade_counter #(.WIDTH(4), .ASYNC_RESET(1'b0)) u3 (
    .clk(clk), .rstN(rstN), .loadN(loadN), .enParallel(enP), .enTrickle(tcLoS),
    .dataIn(dataIn[7:4]), .countOut(hiS), .termCount(tcHiS));

  int checks = 0;
  int errors = 0;
  logic [7:0] model = 8'h00;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    chk({req, " async count"}, {hiA, loA}, model);
    chk({req, " sync count"},  {hiS, loS}, model);
    chk({req, " R8 low tc async"}, tcLoA, ((model[3:0] == 4'hF) && enT) ? 1 : 0);
    chk({req, " R8 low tc sync"},  tcLoS, ((model[3:0] == 4'hF) && enT) ? 1 : 0);
    chk({req, " R9 carry async"}, tcHiA, ((model == 8'hFF) && enT) ? 1 : 0);
    chk({req, " R9 carry sync"},  tcHiS, ((model == 8'hFF) && enT) ? 1 : 0);
  endtask

  // Called just after a falling edge: drive, take one rising edge, check at the next falling edge.
  task automatic step(input logic r, input logic l, input logic p, input logic t,
                      input logic [7:0] d, input string req);
    rstN = r; loadN = l; enP = p; enT = t; dataIn = d;
    @(posedge clk);
    if (!r)          model = 8'h00;
    else if (!l)     model = d;
    else if (p && t) model = model + 8'h01;
    @(negedge clk);
    checkAll(req);
  endtask

  initial begin
    #4000000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R5: reset beats a simultaneous load with both enables high.
    step(1'b0, 1'b0, 1'b1, 1'b1, 8'hA5, "R5 reset over load");
    step(1'b0, 1'b1, 1'b1, 1'b1, 8'h00, "R5 reset held");

    // R1/R2/R9: full sweep through 255 and the wrap to 0.
    for (int i = 0; i < 260; i++)
      step(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R1 R2 R9 sweep");

    // R3: hold under each disabled enable combination.
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'h3C, "R4 preset");
    for (int k = 0; k < 3; k++) begin
      for (int j = 0; j < 2; j++)
        step(1'b1, 1'b1, (k == 1), (k == 0), 8'h00, "R3 hold");
    end

    // R4: load beats counting for several values.
    for (int v = 0; v < 16; v++)
      step(1'b1, 1'b0, 1'b1, 1'b1, 8'(v * 17 + 3), "R4 load over count");

    // R8: loaded all-ones raises tc with enParallel low; enTrickle gates it.
    step(1'b1, 1'b0, 1'b0, 1'b1, 8'h0F, "R8 load 0F");
    step(1'b1, 1'b1, 1'b0, 1'b0, 8'h00, "R8 trickle low");
    step(1'b1, 1'b0, 1'b0, 1'b1, 8'hFF, "R8 R9 load FF");
    step(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R1 R9 wrap from load");

    // R6/R7: mid-cycle reset timing.
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'h42, "R4 preset 42");
    #3 rstN = 1'b0;
    #3;
    chk("R6 async clears without clock", {hiA, loA}, 0);
    chk("R7 sync waits for edge", {hiS, loS}, 8'h42);
    @(posedge clk);
    model = 8'h00;
    @(negedge clk);
    checkAll("R5 R7 cleared at edge");
    step(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R2 count after reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule